// File: doc/BRIEF.md
# UART Host Register Bank

This block is the processor-side register file of a single-channel serial port. A host on a plain synchronous bus (chip select, read and write strobes, a 3-bit address and byte-wide data) reaches eight addresses. Behind them sit the line and modem control bytes, the interrupt enable mask, the FIFO enable, the 16-bit baud divisor and a scratch byte. The line and modem status bytes and the received data come in from neighbouring blocks and are read through the same window. Data written to address 0 is handed to the transmitter as a one-cycle load strobe. A read of received data produces a one-cycle pop strobe.

The block also identifies itself. While both divisor bytes hold zero, a divisor read returns a fixed device code or revision code instead of the stored zero. A single interrupt pin combines the enabled event sources. The transmit source follows the holding register in single-byte mode and the FIFO trigger level in FIFO mode. A bus-mode pin selects whether the pin is active high or active low.

Top module: `uart_regbank`

## Requirements
- R1: Synchronous active-low reset clears line control, modem control, interrupt enable, FIFO enable, divisor and scratch. With no enabled source, the interrupt pin then sits at its inactive level.
- R2: When line control bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 the high byte. When bit 7 is 0 the same addresses reach data and interrupt enable. Address 3 reads back line control.
- R3: While both divisor bytes are 0x00, a divisor-high read returns the device code (default 0x01) and a divisor-low read returns the revision code (default 0x01).
- R4: While either divisor byte is nonzero, both divisor reads return the stored bytes.
- R5: Address 7 reads back the last byte written there.
- R6: Bit 3 of a FIFO-control write (address 2) changes neither the status byte nor the interrupt pin.
- R7: With FIFO mode off (FIFO-control bit 0 = 0), the transmit source is active exactly when the holding-register-empty input is 1.
- R8: With FIFO mode on, the transmit source is active exactly when the above-trigger input is 0.
- R9: The interrupt condition is the OR of four sources, each gated by its enable bit: bit 0 receive data, bit 1 transmit, bit 2 line status, bit 3 modem status.
- R10: With bus-mode 1 the pin equals the condition. With bus-mode 0 it is the inverted condition.
- R11: A read of address 2 returns the status byte. Bit 0 is 0 when an interrupt is pending. Bits 3:1 hold the top pending source: line 011, receive 010, transmit 001, modem 000. Bits 7:6 both equal the FIFO enable.
- R12: With bit 7 of line control clear, a read of address 0 returns the receive data input and pulses the pop strobe, and a write to address 0 pulses the load strobe once. Addresses 5 and 6 return the line and modem status inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| rx_data | input | 8 | Byte at the head of the receive path |
| lsr_in | input | 8 | Line status byte |
| msr_in | input | 8 | Modem status byte |
| rx_avail | input | 1 | Receive data available |
| tx_empty | input | 1 | Holding register / transmit FIFO empty |
| tx_above | input | 1 | Transmit FIFO above trigger level |
| line_evt | input | 1 | Line status event |
| modem_evt | input | 1 | Modem status event |
| bus_mode | input | 1 | 1: active-high pin, 0: active-low pin |
| irq_o | output | 1 | Interrupt pin |
| tx_load | output | 1 | Pulse: write data goes to transmitter |
| rx_pop | output | 1 | Pulse: received byte consumed |
| lcr_o | output | 8 | Line control byte |
| mcr_o | output | 8 | Modem control byte |
| dl_o | output | 16 | Divisor value |
| fifo_en_o | output | 1 | FIFO mode enable |

## Verification
The bench builds the block with its defaults: byte-wide data and device and revision codes of 0x01. Because both codes equal 0x01, a swap of the two codes cannot be seen. A stored divisor of 0x0C in the low byte and 0x02 in the high byte is clearly different from the codes, so it separates the identification path from the stored path. The divisor is written with one byte zero and the other nonzero, which tests the condition that both bytes must be zero. Both bus modes are driven against the same source state.

// File: rtl/uart_rb_pkg.sv
// Shared address map, source codes and field positions of the UART register bank.
package uart_rb_pkg;
    localparam int AW       = 3;
    localparam int NSRC     = 4;
    localparam int DLAB_BIT = 7;
    localparam int CODE_W   = 3;

    typedef enum logic [AW-1:0] {
        A_DATA = 3'd0,
        A_IER  = 3'd1,
        A_ISR  = 3'd2,
        A_LCR  = 3'd3,
        A_MCR  = 3'd4,
        A_LSR  = 3'd5,
        A_MSR  = 3'd6,
        A_SCR  = 3'd7
    } reg_addr_e;

    // Status codes, line status has highest priority.
    typedef enum logic [CODE_W-1:0] {
        SRC_MODEM = 3'b000,
        SRC_TX    = 3'b001,
        SRC_RX    = 3'b010,
        SRC_LINE  = 3'b011
    } irq_src_e;
endpackage

// File: rtl/uart_rb_divisor.sv
// Divisor latch pair with identification readback.
// Holds the two divisor bytes. While both hold zero, the read values are
// the fixed device and revision codes instead of the stored zeros.
// Assumes the write enables are already qualified by the bank decode.
module uart_rb_divisor #(
    parameter int          DW       = 8,
    parameter logic [DW-1:0] DEV_CODE = 8'h01,
    parameter logic [DW-1:0] REV_CODE = 8'h01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] dl_o,
    output logic [DW-1:0]   rd_lo,
    output logic [DW-1:0]   rd_hi
);
    logic [DW-1:0] lo_q, hi_q;
    logic          id_mode;

    // Store each divisor byte on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata;
        end
    end

    // Select identification codes while the whole divisor is zero.
    always_comb begin
        id_mode = (lo_q == '0) && (hi_q == '0);
        rd_lo   = id_mode ? REV_CODE : lo_q;
        rd_hi   = id_mode ? DEV_CODE : hi_q;
        dl_o    = {hi_q, lo_q};
    end
endmodule

// File: rtl/uart_rb_irq.sv
// Interrupt combiner and status byte builder.
// Gates four raw sources with their enable bits, picks the top-priority one
// for the status byte and drives the pin in the polarity bus_mode selects.
// Assumes sources are levels from the neighbouring FIFO and line logic.
module uart_rb_irq
    import uart_rb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            rx_avail,
    input  logic            tx_empty,
    input  logic            tx_above,
    input  logic            line_evt,
    input  logic            modem_evt,
    input  logic            fifo_en,
    input  logic [NSRC-1:0] ier,
    input  logic            bus_mode,
    output logic            irq_pin,
    output logic [DW-1:0]   isr_byte
);
    logic [NSRC-1:0] raw, pend;
    logic            cond;
    irq_src_e        code;

    // Raw sources in enable-bit order; transmit depends on FIFO mode.
    always_comb begin
        raw[0] = rx_avail;
        raw[1] = fifo_en ? !tx_above : tx_empty;
        raw[2] = line_evt;
        raw[3] = modem_evt;
    end

    // Gate every source with its own enable bit.
    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        assign pend[i] = raw[i] & ier[i];
    end

    // Priority encode, then build the pin and the status byte.
    always_comb begin
        cond = |pend;
        if (pend[2])      code = SRC_LINE;
        else if (pend[0]) code = SRC_RX;
        else if (pend[1]) code = SRC_TX;
        else              code = SRC_MODEM;
        irq_pin               = bus_mode ? cond : !cond;
        isr_byte              = '0;
        isr_byte[0]           = !cond;
        isr_byte[CODE_W:1]    = code;
        isr_byte[DW-1]        = fifo_en;
        isr_byte[DW-2]        = fifo_en;
    end
endmodule

// File: rtl/uart_regbank.sv
// UART host register bank, top level.
// Decodes the 8-address host window and holds the control and scratch bytes.
// Line control bit 7 banks addresses 0 and 1 over to the divisor.
// Reads are combinational and return zero when not selected.
// Assumes a single-cycle strobe per access.
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] DEV_CODE = 8'h01,
    parameter logic [DW-1:0] REV_CODE = 8'h01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            rd,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   rx_data,
    input  logic [DW-1:0]   lsr_in,
    input  logic [DW-1:0]   msr_in,
    input  logic            rx_avail,
    input  logic            tx_empty,
    input  logic            tx_above,
    input  logic            line_evt,
    input  logic            modem_evt,
    input  logic            bus_mode,
    output logic            irq_o,
    output logic            tx_load,
    output logic            rx_pop,
    output logic [DW-1:0]   lcr_o,
    output logic [DW-1:0]   mcr_o,
    output logic [2*DW-1:0] dl_o,
    output logic            fifo_en_o
);
    logic [DW-1:0]   lcr_q, mcr_q, scr_q;
    logic [NSRC-1:0] ier_q;
    logic            fifo_en_q;
    logic            dlab, wr_en, rd_en;
    logic            wr_dll, wr_dlm;
    logic [DW-1:0]   dl_rd_lo, dl_rd_hi, isr_byte;

    // Qualified strobes and divisor banking.
    always_comb begin
        dlab    = lcr_q[DLAB_BIT];
        wr_en   = cs && wr;
        rd_en   = cs && rd;
        wr_dll  = wr_en && dlab && (addr == A_DATA);
        wr_dlm  = wr_en && dlab && (addr == A_IER);
        tx_load = wr_en && !dlab && (addr == A_DATA);
        rx_pop  = rd_en && !dlab && (addr == A_DATA);
    end

    // Control, enable and scratch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q     <= '0;
            mcr_q     <= '0;
            scr_q     <= '0;
            ier_q     <= '0;
            fifo_en_q <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_IER: if (!dlab) ier_q <= wdata[NSRC-1:0];
                A_ISR: fifo_en_q <= wdata[0];
                A_LCR: lcr_q <= wdata;
                A_MCR: mcr_q <= wdata;
                A_SCR: scr_q <= wdata;
                default: ;
            endcase
        end
    end

    uart_rb_divisor #(
        .DW       (DW),
        .DEV_CODE (DEV_CODE),
        .REV_CODE (REV_CODE)
    ) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_dll),
        .wr_hi (wr_dlm),
        .wdata (wdata),
        .dl_o  (dl_o),
        .rd_lo (dl_rd_lo),
        .rd_hi (dl_rd_hi)
    );

    uart_rb_irq #(
        .DW (DW)
    ) irq_i (
        .rx_avail  (rx_avail),
        .tx_empty  (tx_empty),
        .tx_above  (tx_above),
        .line_evt  (line_evt),
        .modem_evt (modem_evt),
        .fifo_en   (fifo_en_q),
        .ier       (ier_q),
        .bus_mode  (bus_mode),
        .irq_pin   (irq_o),
        .isr_byte  (isr_byte)
    );

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_DATA: rdata = dlab ? dl_rd_lo : rx_data;
                A_IER:  rdata = dlab ? dl_rd_hi : DW'(ier_q);
                A_ISR:  rdata = isr_byte;
                A_LCR:  rdata = lcr_q;
                A_MCR:  rdata = mcr_q;
                A_LSR:  rdata = lsr_in;
                A_MSR:  rdata = msr_in;
                A_SCR:  rdata = scr_q;
                default: rdata = '0;
            endcase
        end
    end

    assign lcr_o     = lcr_q;
    assign mcr_o     = mcr_q;
    assign fifo_en_o = fifo_en_q;
endmodule

// File: rtl/uart_regbank_chk.sv
// Property checker for uart_regbank, attached with bind below.
module uart_regbank_chk #(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] DEV_CODE = 8'h01,
    parameter logic [DW-1:0] REV_CODE = 8'h01
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs,
    input logic            rd,
    input logic            wr,
    input logic [2:0]      addr,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   rdata,
    input logic [DW-1:0]   lcr_o,
    input logic [2*DW-1:0] dl_o,
    input logic [3:0]      ier_q,
    input logic [DW-1:0]   scr_q,
    input logic            fifo_en_o,
    input logic            bus_mode,
    input logic            irq_o,
    input logic            rx_pop
);
    a_r3_dev_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 3'd1 && lcr_o[7] && dl_o == '0) |-> rdata == DEV_CODE);
    a_r3_rev_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 3'd0 && lcr_o[7] && dl_o == '0) |-> rdata == REV_CODE);
    a_r4_stored_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 3'd0 && lcr_o[7] && dl_o != '0) |-> rdata == dl_o[DW-1:0]);
    a_r2_dll_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 3'd0 && lcr_o[7]) |=> dl_o[DW-1:0] == $past(wdata));
    a_r5_scratch: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 3'd7) |=> scr_q == $past(wdata));
    a_r6_fifo_en: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 3'd2) |=> fifo_en_o == $past(wdata[0]));
    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q == '0) |-> irq_o == !bus_mode);
    a_r12_pop_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (cs && rd && addr == 3'd0 && !lcr_o[7]));
endmodule

bind uart_regbank uart_regbank_chk #(
    .DW       (DW),
    .DEV_CODE (DEV_CODE),
    .REV_CODE (REV_CODE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .rd        (rd),
    .wr        (wr),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .lcr_o     (lcr_o),
    .dl_o      (dl_o),
    .ier_q     (ier_q),
    .scr_q     (scr_q),
    .fifo_en_o (fifo_en_o),
    .bus_mode  (bus_mode),
    .irq_o     (irq_o),
    .rx_pop    (rx_pop)
);

// File: tb/uart_regbank_tb_top.sv
// Scoreboard bench for uart_regbank.
module uart_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  rx_data = 8'hA5, lsr_in = 8'h60, msr_in = 8'h10;
    logic        rx_avail = 1'b0, tx_empty = 1'b1, tx_above = 1'b0;
    logic        line_evt = 1'b0, modem_evt = 1'b0, bus_mode = 1'b1;
    logic        irq_o, tx_load, rx_pop, fifo_en_o;
    logic [7:0]  lcr_o, mcr_o;
    logic [15:0] dl_o;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    logic  mon_req = 1'b0;
    int    checks = 0;
    int    failures = 0;
    int    loads = 0;

    always #2 clk = ~clk;

    uart_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .lsr_in(lsr_in),
        .msr_in(msr_in), .rx_avail(rx_avail), .tx_empty(tx_empty),
        .tx_above(tx_above), .line_evt(line_evt), .modem_evt(modem_evt),
        .bus_mode(bus_mode), .irq_o(irq_o), .tx_load(tx_load), .rx_pop(rx_pop),
        .lcr_o(lcr_o), .mcr_o(mcr_o), .dl_o(dl_o), .fifo_en_o(fifo_en_o)
    );

    // Monitor: pop the expected item and compare mid-cycle.
    always @(negedge clk) begin
        if (mon_req && sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {7'b0, irq_o} : rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    // Count transmit load strobes.
    always @(posedge clk) if (tx_load) loads++;

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cs = 1; wr = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        cs = 0; wr = 0;
    endtask

    task automatic read_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        cs = 1; rd = 1; addr = a;
        sb.push_back('{1'b0, e, tag});
        mon_req = 1;
        @(posedge clk); #1;
        cs = 0; rd = 0; mon_req = 0;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(posedge clk); #1;
        sb.push_back('{1'b1, {7'b0, e}, tag});
        mon_req = 1;
        @(posedge clk); #1;
        mon_req = 0;
    endtask

    task automatic finish_run();
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard not drained actual=%0d expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        irq_chk(1'b0, "R1 pin inactive after reset");
        read_chk(3'd3, 8'h00, "R1 lcr reset");
        read_chk(3'd1, 8'h00, "R1 ier reset");
        read_chk(3'd7, 8'h00, "R1 scratch reset");
        read_chk(3'd2, 8'h01, "R1 R11 status idle");
        // R3 identification with divisor zero
        bus_write(3'd3, 8'h80);
        read_chk(3'd3, 8'h80, "R2 lcr readback");
        read_chk(3'd0, 8'h01, "R3 revision code");
        read_chk(3'd1, 8'h01, "R3 device code");
        // R4 stored values with one byte nonzero
        bus_write(3'd0, 8'h0C);
        read_chk(3'd0, 8'h0C, "R4 low stored");
        read_chk(3'd1, 8'h00, "R4 high stored zero");
        bus_write(3'd0, 8'h00);
        bus_write(3'd1, 8'h02);
        read_chk(3'd0, 8'h00, "R4 low stored zero");
        read_chk(3'd1, 8'h02, "R4 high stored");
        bus_write(3'd1, 8'h00);
        read_chk(3'd1, 8'h01, "R3 device code again");
        // R2 R12 normal bank
        bus_write(3'd3, 8'h03);
        read_chk(3'd0, 8'hA5, "R12 receive data");
        read_chk(3'd1, 8'h00, "R2 ier not divisor");
        bus_write(3'd0, 8'h55);
        checks++;
        if (loads != 1) begin
            failures++;
            $display("FAIL R12 load strobes actual=%0d expected=1", loads);
        end
        read_chk(3'd5, 8'h60, "R12 line status");
        read_chk(3'd6, 8'h10, "R12 modem status");
        bus_write(3'd7, 8'h3C);
        read_chk(3'd7, 8'h3C, "R5 scratch");
        // R7 single-byte mode transmit source
        bus_write(3'd1, 8'h02);
        irq_chk(1'b1, "R7 holding empty");
        read_chk(3'd2, 8'h02, "R11 transmit code");
        tx_empty = 0;
        irq_chk(1'b0, "R7 holding full");
        // R10 polarity
        bus_mode = 0;
        irq_chk(1'b1, "R10 low mode idle high");
        tx_empty = 1;
        irq_chk(1'b0, "R10 low mode asserted low");
        bus_mode = 1;
        // R8 FIFO mode
        tx_empty = 0; tx_above = 1;
        bus_write(3'd2, 8'h01);
        irq_chk(1'b0, "R8 above trigger");
        read_chk(3'd2, 8'hC1, "R11 fifo bits idle");
        tx_above = 0;
        irq_chk(1'b1, "R8 below trigger");
        read_chk(3'd2, 8'hC2, "R11 fifo transmit");
        // R6 bit 3 no effect
        bus_write(3'd2, 8'h09);
        irq_chk(1'b1, "R6 bit3 fifo on pin");
        read_chk(3'd2, 8'hC2, "R6 bit3 fifo on status");
        bus_write(3'd2, 8'h08);
        irq_chk(1'b0, "R6 bit3 fifo off pin");
        read_chk(3'd2, 8'h01, "R6 bit3 fifo off status");
        // R9 R11 priority and gating
        bus_write(3'd1, 8'h0F);
        rx_avail = 1; line_evt = 1; modem_evt = 1;
        read_chk(3'd2, 8'h06, "R11 line first");
        line_evt = 0;
        read_chk(3'd2, 8'h04, "R11 receive next");
        rx_avail = 0;
        read_chk(3'd2, 8'h00, "R11 modem last");
        bus_write(3'd1, 8'h07);
        irq_chk(1'b0, "R9 modem masked");
        read_chk(3'd2, 8'h01, "R9 masked status");
        bus_write(3'd1, 8'h08);
        irq_chk(1'b1, "R9 modem enabled");
        // R1 reset again clears
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        read_chk(3'd7, 8'h00, "R1 scratch cleared");
        irq_chk(1'b0, "R1 pin inactive after second reset");
        finish_run();
    end
endmodule